// File: doc/BRIEF.md
# Sync Format Classifier with HD Flag

This block watches the sliced sync of an analog video input and decides which family of timing it carries: standard definition, enhanced (progressive) definition, high definition with tri-level sync, or anything else (treated as PC or unknown timing). It measures the line period in clock cycles from one negative sync edge to the next. It also notes whether a positive sync tip follows each negative pulse. The period ranges for each family are parameters.

A decision is committed only at a vertical sync strobe, and only after two consecutive fields have produced the same candidate. At that point the `locked_o` indication rises and the active-low `hd_flag_n_o` is updated. The flag goes low only when the committed class is tri-level high definition, and it rests high after reset. A jump in line period beyond a tolerance drops the lock at once and restarts the field count. A field without a single sync line does the same. Re-acquisition after any change is automatic, with no reset. The three inputs are plain level and strobe signals, already synchronous to `clk`. There is no data stream, so no valid/ready handshake or back-pressure applies.

Top module: `sfc_format_detect`

## Requirements
- R1: After reset `hd_flag_n_o` is 1, `locked_o` is 0 and `fmt_class_o` is 0 (SD).
- R2: The line period is the number of clock cycles between two rising edges of `sync_neg_i`. A period in [SD_MIN,SD_MAX] gives class 0 (SD) and one in [ED_MIN,ED_MAX] gives class 1 (ED). A period in [HD_MIN,HD_MAX] gives class 2 (HD) only while tri-level sync is declared. Every other case gives class 3 (PC), including an HD-range period with bi-level sync.
- R3: A line counts as tri-level when `sync_pos_i` is high in some cycle after `sync_neg_i` falls and before its next rise. Tri-level sync is declared after TRI_LINES consecutive such lines and cleared after TRI_LINES consecutive lines without one. A single line that lacks the positive pulse changes nothing.
- R4: `hd_flag_n_o` is 0 only while the committed class is 2 (HD).
- R5: At a `vsync_stb_i` cycle, a commit happens when the field just ended and the one before it both held at least one line, gave the same candidate class, and saw no period jump. The commit writes `fmt_class_o` and `hd_flag_n_o` and sets `locked_o` to 1 in that same update.
- R6: A measured period that differs from the previous one by more than TOL clears `locked_o` on the next cycle and restarts the field count. A difference of exactly TOL does not.
- R7: `fmt_class_o` and `hd_flag_n_o` change only on the clock edge that samples a `vsync_stb_i` pulse.
- R8: At a strobe whose candidate differs from that of the previous field, `locked_o` falls and the committed class and flag keep their old values.
- R9: A strobe that ends a field without any measured line clears `locked_o`.
- R10: After a change of format, the new class is committed at the second strobe after the change, with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_neg_i | input | 1 | Sliced negative sync, 1 while the input is in the negative sync tip |
| sync_pos_i | input | 1 | Positive-tip comparator, 1 while the input is in a positive sync tip |
| vsync_stb_i | input | 1 | One-cycle strobe at each vertical sync |
| fmt_class_o | output | 2 | Committed class: 0 SD, 1 ED, 2 HD, 3 PC |
| locked_o | output | 1 | 1 while the committed class is backed by agreeing fields |
| hd_flag_n_o | output | 1 | Active-low HD tri-level flag |

## Verification
A line's period and positive-tip result appear one cycle after the rising edge that closes the line. The tri-level state follows one cycle later. A period jump clears the lock on the second edge after that rise. Class, flag and lock move on the edge that samples the strobe. The bench places each strobe two cycles before the end of a field's last line and reads the outputs at the falling edge of that line's final cycle, when all of these have settled. The next field cannot alter them before then.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    CLS_SD = 2'd0,
    CLS_ED = 2'd1,
    CLS_HD = 2'd2,
    CLS_PC = 2'd3
  } fmt_cls_e;
endpackage

// File: rtl/sfc_line_meter.sv
module sfc_line_meter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             neg_i,
  input  logic             pos_i,
  output logic             line_stb_o,
  output logic [CNT_W-1:0] period_o,
  output logic             pos_seen_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             neg_q;
  logic             armed;
  logic             pos_acc;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise = neg_i & ~neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q      <= 1'b0;
      armed      <= 1'b0;
      pos_acc    <= 1'b0;
      cnt        <= '0;
      line_stb_o <= 1'b0;
      period_o   <= '0;
      pos_seen_o <= 1'b0;
    end else begin
      neg_q      <= neg_i;
      line_stb_o <= 1'b0;
      if (rise) begin
        cnt     <= CNT_ONE;
        armed   <= 1'b1;
        pos_acc <= 1'b0;
        if (armed) begin
          line_stb_o <= 1'b1;
          period_o   <= cnt;
          pos_seen_o <= pos_acc;
        end
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
        if (pos_i && !neg_i) pos_acc <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfc_tri_detect.sv
module sfc_tri_detect #(
  parameter int RUN_LINES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb_i,
  input  logic pos_seen_i,
  output logic tri_o
);
  localparam int RW = $clog2(RUN_LINES + 1);
  localparam logic [RW-1:0] RUN_MAX  = RW'(RUN_LINES);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LINES - 1);

  logic [RW-1:0] yes_run;
  logic [RW-1:0] no_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yes_run <= '0;
      no_run  <= '0;
      tri_o   <= 1'b0;
    end else if (line_stb_i) begin
      if (pos_seen_i) begin
        no_run <= '0;
        if (yes_run != RUN_MAX) yes_run <= yes_run + RW'(1);
        if (yes_run >= RUN_LAST) tri_o <= 1'b1;
      end else begin
        yes_run <= '0;
        if (no_run != RUN_MAX) no_run <= no_run + RW'(1);
        if (no_run >= RUN_LAST) tri_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sfc_range_class.sv
module sfc_range_class
  import sfc_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int SD_MIN = 6300,
  parameter int SD_MAX = 6500,
  parameter int ED_MIN = 3100,
  parameter int ED_MAX = 3300,
  parameter int HD_MIN = 1400,
  parameter int HD_MAX = 3050
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic             tri_i,
  output fmt_cls_e         cls_o
);
  logic in_sd, in_ed, in_hd;

  assign in_sd = (period_i >= CNT_W'(SD_MIN)) && (period_i <= CNT_W'(SD_MAX));
  assign in_ed = (period_i >= CNT_W'(ED_MIN)) && (period_i <= CNT_W'(ED_MAX));
  assign in_hd = (period_i >= CNT_W'(HD_MIN)) && (period_i <= CNT_W'(HD_MAX));

  always_comb begin
    if (in_hd && tri_i)  cls_o = CLS_HD;
    else if (in_sd)      cls_o = CLS_SD;
    else if (in_ed)      cls_o = CLS_ED;
    else                 cls_o = CLS_PC;
  end
endmodule

// File: rtl/sfc_format_detect.sv
module sfc_format_detect
  import sfc_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int TRI_LINES = 16,
  parameter int TOL       = 8,
  parameter int SD_MIN    = 6300,
  parameter int SD_MAX    = 6500,
  parameter int ED_MIN    = 3100,
  parameter int ED_MAX    = 3300,
  parameter int HD_MIN    = 1400,
  parameter int HD_MAX    = 3050
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_neg_i,
  input  logic       sync_pos_i,
  input  logic       vsync_stb_i,
  output logic [1:0] fmt_class_o,
  output logic       locked_o,
  output logic       hd_flag_n_o
);
  localparam logic [CNT_W-1:0] TOL_C = CNT_W'(TOL);

  logic             line_stb_w;
  logic [CNT_W-1:0] period_w;
  logic             pos_seen_w;
  logic             tri_w;
  fmt_cls_e         cand_w;

  sfc_line_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .neg_i(sync_neg_i), .pos_i(sync_pos_i),
    .line_stb_o(line_stb_w), .period_o(period_w), .pos_seen_o(pos_seen_w)
  );

  sfc_tri_detect #(.RUN_LINES(TRI_LINES)) u_tri (
    .clk(clk), .rst_n(rst_n), .line_stb_i(line_stb_w),
    .pos_seen_i(pos_seen_w), .tri_o(tri_w)
  );

  sfc_range_class #(
    .CNT_W(CNT_W), .SD_MIN(SD_MIN), .SD_MAX(SD_MAX), .ED_MIN(ED_MIN),
    .ED_MAX(ED_MAX), .HD_MIN(HD_MIN), .HD_MAX(HD_MAX)
  ) u_class (
    .period_i(period_w), .tri_i(tri_w), .cls_o(cand_w)
  );

  // period stability
  logic [CNT_W-1:0] prev_period;
  logic             prev_valid;
  logic [CNT_W-1:0] diff_w;
  logic             jump_w;

  assign diff_w = (period_w > prev_period) ? (period_w - prev_period)
                                           : (prev_period - period_w);
  assign jump_w = line_stb_w && prev_valid && (diff_w > TOL_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_period <= '0;
      prev_valid  <= 1'b0;
    end else if (line_stb_w) begin
      prev_period <= period_w;
      prev_valid  <= 1'b1;
    end
  end

  // field commit
  fmt_cls_e cls_q, prev_cand;
  logic     have_prev, line_in_field, lock_q, hd_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q         <= CLS_SD;
      prev_cand     <= CLS_SD;
      have_prev     <= 1'b0;
      line_in_field <= 1'b0;
      lock_q        <= 1'b0;
      hd_n_q        <= 1'b1;
    end else if (jump_w) begin
      lock_q        <= 1'b0;
      have_prev     <= 1'b0;
      line_in_field <= 1'b1;
    end else if (vsync_stb_i) begin
      line_in_field <= line_stb_w;
      if (!line_in_field) begin
        lock_q    <= 1'b0;
        have_prev <= 1'b0;
      end else begin
        prev_cand <= cand_w;
        have_prev <= 1'b1;
        if (have_prev && (cand_w == prev_cand)) begin
          lock_q <= 1'b1;
          cls_q  <= cand_w;
          hd_n_q <= (cand_w != CLS_HD);
        end else begin
          lock_q <= 1'b0;
        end
      end
    end else if (line_stb_w) begin
      line_in_field <= 1'b1;
    end
  end

  assign fmt_class_o = cls_q;
  assign locked_o    = lock_q;
  assign hd_flag_n_o = hd_n_q;
endmodule

// File: rtl/sfc_format_checker.sv
module sfc_format_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       vsync_stb_i,
  input logic [1:0] fmt_class_o,
  input logic       locked_o,
  input logic       hd_flag_n_o,
  input logic       jump_w,
  input logic       line_stb_w,
  input logic       tri_w
);
  p_flag_needs_hd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_flag_n_o |-> (fmt_class_o == 2'd2));

  p_jump_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_w |=> !locked_o);

  p_commit_only_at_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_stb_i |=> ($stable(fmt_class_o) && $stable(hd_flag_n_o)));

  p_lock_rises_at_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(vsync_stb_i));

  p_tri_moves_per_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb_w |=> $stable(tri_w));
endmodule

bind sfc_format_detect sfc_format_checker u_sfc_chk (
  .clk(clk), .rst_n(rst_n), .vsync_stb_i(vsync_stb_i),
  .fmt_class_o(fmt_class_o), .locked_o(locked_o), .hd_flag_n_o(hd_flag_n_o),
  .jump_w(jump_w), .line_stb_w(line_stb_w), .tri_w(tri_w)
);

// File: tb/tb_sfc_format_detect.sv
module tb_sfc_format_detect;
  localparam int TRI_N  = 16;
  localparam int TOL    = 4;
  localparam int SD_MIN = 120, SD_MAX = 150;
  localparam int ED_MIN = 80,  ED_MAX = 100;
  localparam int HD_MIN = 40,  HD_MAX = 60;
  localparam int LINES  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_neg = 1'b0, sync_pos = 1'b0, vstb = 1'b0;
  logic [1:0] fmt_class;
  logic locked, hd_n;
  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sfc_format_detect #(
    .CNT_W(10), .TRI_LINES(TRI_N), .TOL(TOL),
    .SD_MIN(SD_MIN), .SD_MAX(SD_MAX), .ED_MIN(ED_MIN), .ED_MAX(ED_MAX),
    .HD_MIN(HD_MIN), .HD_MAX(HD_MAX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sync_neg_i(sync_neg), .sync_pos_i(sync_pos),
    .vsync_stb_i(vstb), .fmt_class_o(fmt_class), .locked_o(locked),
    .hd_flag_n_o(hd_n)
  );

  function automatic logic [1:0] exp_cls(int per, bit tri_lvl);
    if (per >= HD_MIN && per <= HD_MAX && tri_lvl) return 2'd2;
    if (per >= SD_MIN && per <= SD_MAX) return 2'd0;
    if (per >= ED_MIN && per <= ED_MAX) return 2'd1;
    return 2'd3;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, int cls, int lk);
    chk({req, " class"}, fmt_class, cls);
    chk({req, " locked"}, locked, lk);
    chk({req, " flag"}, hd_n, (cls == 2) ? 0 : 1);
  endtask

  task automatic one_line(int per, bit pos, bit stb);
    for (int c = 0; c < per; c++) begin
      @(negedge clk);
      sync_neg = (c < 6);
      sync_pos = pos && (c >= 8) && (c < 14);
      vstb     = stb && (c == per - 2);
    end
  endtask

  task automatic field(int per, bit pos, bit jit, int miss, int odd_line, int odd_per);
    for (int l = 0; l < LINES; l++) begin
      int p;
      p = per + (jit ? int'($urandom_range(0, 2)) : 0);
      if (l == odd_line) p = odd_per;
      one_line(p, pos && (l != miss), l == LINES - 1);
    end
  endtask

  task automatic empty_field();
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      sync_neg = 1'b0; sync_pos = 1'b0;
      vstb = (c == 25);
    end
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int prev_cls;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_state("R1 reset", 0, 0);
    rst_n = 1'b1;

    // SD acquisition, R5/R10
    field(135, 0, 0, -1, -1, 0);
    chk_state("R5 first field no commit", 0, 0);
    field(135, 0, 0, -1, -1, 0);
    chk_state("R5 SD commit", 0, 1);

    // R6 a step of exactly TOL keeps lock
    field(135, 0, 0, -1, 5, 135 + TOL);
    chk_state("R6 within tolerance", 0, 1);
    // R6 a step above TOL drops lock, class kept
    field(135, 0, 0, -1, 5, 135 + TOL + 1);
    chk_state("R6 jump unlocks", 0, 0);
    field(135, 0, 0, -1, -1, 0);
    chk_state("R6 relock", 0, 1);

    // HD tri-level: R3/R4/R7/R8/R10
    field(60, 1, 0, -1, -1, 0);
    chk_state("R7 flag held before commit", 0, 0);
    field(60, 1, 0, -1, -1, 0);
    chk_state("R4 HD commit flag low", 2, 1);
    field(60, 1, 0, 7, -1, 0);
    chk_state("R3 single missing pulse ignored", 2, 1);

    // same period, bi-level -> PC: R2/R8
    field(60, 0, 0, -1, -1, 0);
    chk_state("R8 candidate change unlocks, class kept", 2, 0);
    field(60, 0, 0, -1, -1, 0);
    chk_state("R2 HD-range bi-level is PC", 3, 1);

    // R9 field with no lines
    empty_field();
    chk_state("R9 empty field unlocks", 3, 0);

    // R2 range boundaries
    field(150, 0, 0, -1, -1, 0);
    field(150, 0, 0, -1, -1, 0);
    chk_state("R2 SD_MAX is SD", 0, 1);
    field(151, 0, 0, -1, -1, 0);
    field(151, 0, 0, -1, -1, 0);
    chk_state("R2 SD_MAX+1 is PC", 3, 1);
    field(80, 0, 0, -1, -1, 0);
    field(80, 0, 0, -1, -1, 0);
    chk_state("R2 ED_MIN is ED", 1, 1);
    field(40, 1, 0, -1, -1, 0);
    field(40, 1, 0, -1, -1, 0);
    chk_state("R2 HD_MIN tri is HD", 2, 1);

    // random segments
    prev_cls = 2;
    for (int s = 0; s < 8; s++) begin
      int k, base, ec;
      bit pos;
      k = int'($urandom_range(0, 4));
      case (k)
        0: begin base = int'($urandom_range(SD_MIN, SD_MAX - 2)); pos = 0; end
        1: begin base = int'($urandom_range(ED_MIN, ED_MAX - 2)); pos = 0; end
        2: begin base = int'($urandom_range(HD_MIN, HD_MAX - 2)); pos = 1; end
        3: begin base = int'($urandom_range(HD_MIN, HD_MAX - 2)); pos = 0; end
        default: begin base = int'($urandom_range(105, 115)); pos = 0; end
      endcase
      ec = exp_cls(base, pos);
      field(base, pos, 1, -1, -1, 0);
      if (ec != prev_cls) chk_state("R8 random change unlocks", prev_cls, 0);
      field(base, pos, 1, -1, -1, 0);
      chk_state("R10 random reacquire", ec, 1);
      field(base, pos, 1, -1, -1, 0);
      chk_state("R5 random hold", ec, 1);
      prev_cls = ec;
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule